// File: doc/BRIEF.md
# Cable Port Status Register Page

This block holds the status and control registers of one cable port of a serial-bus physical layer. Software reaches them as two byte registers through a small register interface: an address, a write strobe, write data and a combinational read bus. The raw connection-detect and incoming-bias-detect inputs pass through two separate debounce timers. The results of the tree-identify and self-identify processes arrive as strobes. The block turns the line-receiver comparator flags of both line pairs into 2-bit state codes.

The page stores the child/parent result and the peer speed. Both are marked invalid from a bus reset until the matching identify process reports completion, and the two valid flags are brought out as ports. The disable, interrupt-enable and fault bits keep their values across a bus reset, and only the asynchronous hardware reset clears them. Resume and suspend faults latch into a write-one-to-clear bit. Changes of the debounced status bits and new faults raise a one-cycle port-event interrupt toward the link when the interrupt enable is set.

Top module: `cport_status_page`

## Requirements
- R1: Each line pair reports a 2-bit state: only the high-impedance flag set gives 11, only the one flag gives 01, only the zero flag gives 10, any other flag combination gives 00. Pair A reads at offset 0 bits 7:6 and pair B reads at offset 0 bits 5:4.
- R2: The connection bit (offset 0 bit 2) becomes 1 at the CON_CYC-th consecutive clock edge at which raw_conn is sampled high. A low sample clears the bit and restarts the count at the next edge.
- R3: The bias bit (offset 0 bit 1) behaves the same way with raw_bias and BIAS_CYC.
- R4: A tree_done strobe stores tree_child (1 = child, 0 = parent) and marks the child result valid. The child bit is offset 0 bit 3.
- R5: The child bit reads 1 while the port is not connected, disabled (dis bit), suspended (port_susp) or the child result is invalid.
- R6: A bus_rst pulse clears child_vld and spd_vld at the next edge, and it wins over a completion strobe in the same cycle. While a result is invalid, child reads 1 and peer speed reads 000.
- R7: A selfid_done strobe stores peer_spd and marks it valid. Peer speed reads at offset 1 bits 7:5 (000 = S100, 001 = S200, 010 = S400).
- R8: The disable bit is offset 0 bit 0 and can be read and written. A bus reset does not change it.
- R9: The interrupt-enable bit is offset 1 bit 4 and can be read and written. A bus reset does not change it.
- R10: The fault bit (offset 1 bit 3) sets on rsm_chk while the debounced bias is 0 or on sus_chk while it is 1. Writing 1 to it clears it, and a set in the same cycle wins over the clear.
- R11: port_evt_irq is high for exactly the one cycle after the connection bit or the bias bit changes, or after the fault bit sets, and only while the interrupt enable is 1.
- R12: hrst_n low clears every bit, so offset 0 reads 08h and offset 1 reads 00h. A bus reset keeps the connection, bias, disable, interrupt-enable and fault bits.
- R13: Offsets 2 to 7 read 00h and ignore writes. Only the disable, interrupt-enable and fault bits take write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_rst | input | 1 | Bus reset pulse, synchronous |
| raw_conn | input | 1 | Raw connection detect |
| raw_bias | input | 1 | Raw incoming cable bias detect |
| pair_z | input | 2 | High-impedance comparator flag, index 0 = pair A, index 1 = pair B |
| pair_one | input | 2 | One-level comparator flag per pair |
| pair_zero | input | 2 | Zero-level comparator flag per pair |
| tree_done | input | 1 | Tree identification complete strobe |
| tree_child | input | 1 | Child result sampled with tree_done |
| selfid_done | input | 1 | Self identification complete strobe |
| peer_spd | input | 3 | Peer speed code sampled with selfid_done |
| port_susp | input | 1 | Port is in the suspended state |
| rsm_chk | input | 1 | Resume bias check strobe |
| sus_chk | input | 1 | Suspend bias check strobe |
| reg_addr | input | ADDR_W | Register offset within the page |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| port_evt_irq | output | 1 | Port event interrupt pulse |
| child_vld | output | 1 | Child result is valid |
| spd_vld | output | 1 | Peer speed is valid |

## Verification
The bench drops raw_conn one sample short of the debounce length. A timer that did not restart would then report a connection early, and one that was off by one edge would set the bit a cycle away from the model. It issues a bus reset together with a tree_done strobe, and a design that let the strobe win would leave child_vld high. A fault check in the same cycle as a write-one-to-clear must leave the fault set, and a bus reset must not clear the disable bit. The bench also checks that the interrupt pulse lasts one cycle and stays silent when the enable is off, and that writes to reserved offsets are ignored.

// File: rtl/cps_pkg.sv
package cps_pkg;
   // line-pair state codes
   localparam logic [1:0] LINE_Z    = 2'b11;
   localparam logic [1:0] LINE_ONE  = 2'b01;
   localparam logic [1:0] LINE_ZERO = 2'b10;
   localparam logic [1:0] LINE_BAD  = 2'b00;

   // page offsets
   localparam int unsigned OFS_STAT = 0;
   localparam int unsigned OFS_PEER = 1;

   // bit positions in the status byte
   localparam int unsigned B_CHILD = 3;
   localparam int unsigned B_CONN  = 2;
   localparam int unsigned B_BIAS  = 1;
   localparam int unsigned B_DIS   = 0;

   // bit positions in the peer byte
   localparam int unsigned B_IE    = 4;
   localparam int unsigned B_FAULT = 3;
endpackage

// File: rtl/cps_debounce.sv
module cps_debounce #(
   parameter int unsigned CYCLES = 4
) (
   input  logic clk,
   input  logic hrst_n,
   input  logic raw,
   output logic stable
);
   if (CYCLES < 1) begin : g_bad_len
      $error("cps_debounce: CYCLES must be at least 1");
   end

   if (CYCLES == 1) begin : g_direct
      always_ff @(posedge clk or negedge hrst_n) begin
         if (!hrst_n) stable <= 1'b0;
         else         stable <= raw;
      end
   end else begin : g_count
      localparam int unsigned CW = $clog2(CYCLES);
      localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge hrst_n) begin
         if (!hrst_n) begin
            cnt    <= '0;
            stable <= 1'b0;
         end else if (!raw) begin
            cnt    <= '0;
            stable <= 1'b0;
         end else if (!stable) begin
            if (cnt == LAST) stable <= 1'b1;
            else             cnt    <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cps_line_enc.sv
module cps_line_enc
   import cps_pkg::*;
(
   input  logic       flag_z,
   input  logic       flag_one,
   input  logic       flag_zero,
   output logic [1:0] code
);
   always_comb begin
      unique case ({flag_z, flag_one, flag_zero})
         3'b100:  code = LINE_Z;
         3'b010:  code = LINE_ONE;
         3'b001:  code = LINE_ZERO;
         default: code = LINE_BAD;
      endcase
   end
endmodule

// File: rtl/cport_status_page.sv
module cport_status_page
   import cps_pkg::*;
#(
   parameter int unsigned CON_CYC  = 42_625_000,
   parameter int unsigned BIAS_CYC = 6_500,
   parameter int unsigned ADDR_W   = 3
) (
   input  logic              clk,
   input  logic              hrst_n,
   input  logic              bus_rst,
   input  logic              raw_conn,
   input  logic              raw_bias,
   input  logic [1:0]        pair_z,
   input  logic [1:0]        pair_one,
   input  logic [1:0]        pair_zero,
   input  logic              tree_done,
   input  logic              tree_child,
   input  logic              selfid_done,
   input  logic [2:0]        peer_spd,
   input  logic              port_susp,
   input  logic              rsm_chk,
   input  logic              sus_chk,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              port_evt_irq,
   output logic              child_vld,
   output logic              spd_vld
);
   if (ADDR_W < 1) begin : g_bad_addr
      $error("cport_status_page: ADDR_W must be at least 1");
   end

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_PEER = ADDR_W'(OFS_PEER);
   localparam int unsigned NPAIR = 2;

   logic       conn_ok, bias_ok;
   logic [1:0] pair_code [NPAIR];
   logic       child_q, dis_q, ie_q, fault_q;
   logic [2:0] spd_q;
   logic       conn_d, bias_d, fault_d;
   logic       wr_stat, wr_peer, fault_set, child_rd;

   cps_debounce #(.CYCLES(CON_CYC)) u_conn_deb (
      .clk(clk), .hrst_n(hrst_n), .raw(raw_conn), .stable(conn_ok));

   cps_debounce #(.CYCLES(BIAS_CYC)) u_bias_deb (
      .clk(clk), .hrst_n(hrst_n), .raw(raw_bias), .stable(bias_ok));

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      cps_line_enc u_enc (
         .flag_z(pair_z[p]), .flag_one(pair_one[p]),
         .flag_zero(pair_zero[p]), .code(pair_code[p]));
   end

   assign wr_stat   = reg_wr && (reg_addr == A_STAT);
   assign wr_peer   = reg_wr && (reg_addr == A_PEER);
   assign fault_set = (rsm_chk && !bias_ok) || (sus_chk && bias_ok);

   // results of the identify processes: bus reset invalidates them
   always_ff @(posedge clk or negedge hrst_n) begin
      if (!hrst_n) begin
         child_q   <= 1'b0;
         child_vld <= 1'b0;
         spd_q     <= '0;
         spd_vld   <= 1'b0;
      end else if (bus_rst) begin
         child_vld <= 1'b0;
         spd_vld   <= 1'b0;
      end else begin
         if (tree_done) begin
            child_q   <= tree_child;
            child_vld <= 1'b1;
         end
         if (selfid_done) begin
            spd_q   <= peer_spd;
            spd_vld <= 1'b1;
         end
      end
   end

   // controls: hardware reset only
   always_ff @(posedge clk or negedge hrst_n) begin
      if (!hrst_n) begin
         dis_q   <= 1'b0;
         ie_q    <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         if (wr_stat) dis_q <= reg_wdata[B_DIS];
         if (wr_peer) ie_q  <= reg_wdata[B_IE];
         if (fault_set)
            fault_q <= 1'b1;
         else if (wr_peer && reg_wdata[B_FAULT])
            fault_q <= 1'b0;
      end
   end

   // event history
   always_ff @(posedge clk or negedge hrst_n) begin
      if (!hrst_n) begin
         conn_d  <= 1'b0;
         bias_d  <= 1'b0;
         fault_d <= 1'b0;
      end else begin
         conn_d  <= conn_ok;
         bias_d  <= bias_ok;
         fault_d <= fault_q;
      end
   end

   assign port_evt_irq = ie_q && ((conn_ok ^ conn_d) || (bias_ok ^ bias_d)
                                  || (fault_q && !fault_d));

   assign child_rd = (!conn_ok || dis_q || port_susp || !child_vld) ? 1'b1 : child_q;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_STAT) begin
         reg_rdata[7:6]     = pair_code[0];
         reg_rdata[5:4]     = pair_code[1];
         reg_rdata[B_CHILD] = child_rd;
         reg_rdata[B_CONN]  = conn_ok;
         reg_rdata[B_BIAS]  = bias_ok;
         reg_rdata[B_DIS]   = dis_q;
      end else if (reg_addr == A_PEER) begin
         reg_rdata[7:5]     = spd_vld ? spd_q : 3'b000;
         reg_rdata[B_IE]    = ie_q;
         reg_rdata[B_FAULT] = fault_q;
      end
   end
endmodule

// File: rtl/cps_page_chk.sv
module cps_page_chk #(
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              hrst_n,
   input logic              bus_rst,
   input logic              raw_conn,
   input logic              raw_bias,
   input logic              port_susp,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic [7:0]        reg_wdata,
   input logic [7:0]        reg_rdata,
   input logic              port_evt_irq,
   input logic              child_vld,
   input logic              spd_vld,
   input logic              conn_ok,
   input logic              bias_ok,
   input logic              dis_q,
   input logic              ie_q,
   input logic              fault_q
);
   a_r2_conn_needs_raw: assert property (@(posedge clk) disable iff (!hrst_n)
      $rose(conn_ok) |-> $past(raw_conn));

   a_r2_conn_drop: assert property (@(posedge clk) disable iff (!hrst_n)
      !raw_conn |=> !conn_ok);

   a_r3_bias_drop: assert property (@(posedge clk) disable iff (!hrst_n)
      !raw_bias |=> !bias_ok);

   a_r5_child_forced: assert property (@(posedge clk) disable iff (!hrst_n)
      (reg_addr == '0 && (!conn_ok || dis_q || port_susp)) |-> reg_rdata[3]);

   a_r6_busrst_invalid: assert property (@(posedge clk) disable iff (!hrst_n)
      bus_rst |=> (!child_vld && !spd_vld));

   a_r8_dis_keeps: assert property (@(posedge clk) disable iff (!hrst_n)
      (bus_rst && !reg_wr) |=> $stable(dis_q));

   a_r10_fault_clear_by_write: assert property (@(posedge clk) disable iff (!hrst_n)
      $fell(fault_q) |-> $past(reg_wr && reg_addr == ADDR_W'(1) && reg_wdata[3]));

   a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!hrst_n)
      port_evt_irq |-> ie_q);

   a_r13_reserved_zero: assert property (@(posedge clk) disable iff (!hrst_n)
      (reg_addr > ADDR_W'(1)) |-> (reg_rdata == 8'h00));
endmodule

bind cport_status_page cps_page_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .hrst_n(hrst_n), .bus_rst(bus_rst), .raw_conn(raw_conn),
   .raw_bias(raw_bias), .port_susp(port_susp), .reg_addr(reg_addr),
   .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .port_evt_irq(port_evt_irq), .child_vld(child_vld), .spd_vld(spd_vld),
   .conn_ok(conn_ok), .bias_ok(bias_ok), .dis_q(dis_q), .ie_q(ie_q),
   .fault_q(fault_q));

// File: tb/cport_status_page_test.sv
`timescale 1ns/100ps
module cport_status_page_test;
   localparam int CON  = 20;
   localparam int BIAS = 6;

   logic       clk = 0;
   logic       hrst_n = 0;
   logic       bus_rst = 0, raw_conn = 0, raw_bias = 0;
   logic [1:0] pair_z = 0, pair_one = 0, pair_zero = 0;
   logic       tree_done = 0, tree_child = 0, selfid_done = 0;
   logic [2:0] peer_spd = 0;
   logic       port_susp = 0, rsm_chk = 0, sus_chk = 0;
   logic [2:0] reg_addr = 0;
   logic       reg_wr = 0;
   logic [7:0] reg_wdata = 0;
   logic [7:0] reg_rdata;
   logic       port_evt_irq, child_vld, spd_vld;

   int tests = 0, fails = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   cport_status_page #(.CON_CYC(CON), .BIAS_CYC(BIAS), .ADDR_W(3)) uut (
      .clk(clk), .hrst_n(hrst_n), .bus_rst(bus_rst), .raw_conn(raw_conn),
      .raw_bias(raw_bias), .pair_z(pair_z), .pair_one(pair_one),
      .pair_zero(pair_zero), .tree_done(tree_done), .tree_child(tree_child),
      .selfid_done(selfid_done), .peer_spd(peer_spd), .port_susp(port_susp),
      .rsm_chk(rsm_chk), .sus_chk(sus_chk), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .port_evt_irq(port_evt_irq), .child_vld(child_vld), .spd_vld(spd_vld));

   // ---------------- behavioural reference ----------------
   int   m_crun = 0, m_brun = 0;
   bit   m_con = 0, m_bias = 0, m_con_d = 0, m_bias_d = 0, m_fault_d = 0;
   bit   m_child = 0, m_cv = 0, m_sv = 0, m_dis = 0, m_ie = 0, m_fault = 0;
   bit [2:0] m_spd = 0;

   always @(posedge clk or negedge hrst_n) begin
      if (!hrst_n) begin
         m_crun = 0; m_brun = 0; m_con = 0; m_bias = 0;
         m_con_d = 0; m_bias_d = 0; m_fault_d = 0;
         m_child = 0; m_cv = 0; m_sv = 0; m_dis = 0; m_ie = 0; m_fault = 0;
         m_spd = 0;
      end else begin
         bit fset;
         fset = (rsm_chk && !m_bias) || (sus_chk && m_bias);
         m_con_d = m_con; m_bias_d = m_bias; m_fault_d = m_fault;
         m_crun = raw_conn ? ((m_crun < CON) ? m_crun + 1 : CON) : 0;
         m_brun = raw_bias ? ((m_brun < BIAS) ? m_brun + 1 : BIAS) : 0;
         m_con  = (m_crun >= CON);
         m_bias = (m_brun >= BIAS);
         if (bus_rst) begin
            m_cv = 0; m_sv = 0;
         end else begin
            if (tree_done)   begin m_child = tree_child; m_cv = 1; end
            if (selfid_done) begin m_spd = peer_spd;     m_sv = 1; end
         end
         if (reg_wr && reg_addr == 0) m_dis = reg_wdata[0];
         if (reg_wr && reg_addr == 1) m_ie  = reg_wdata[4];
         if (fset) m_fault = 1;
         else if (reg_wr && reg_addr == 1 && reg_wdata[3]) m_fault = 0;
      end
   end

   function automatic bit [1:0] enc(bit z, bit o, bit zz);
      if (z && !o && !zz) return 2'b11;
      if (!z && o && !zz) return 2'b01;
      if (!z && !o && zz) return 2'b10;
      return 2'b00;
   endfunction

   function automatic bit [7:0] exp_read(bit [2:0] a);
      bit ch;
      ch = (!m_con || m_dis || port_susp || !m_cv) ? 1'b1 : m_child;
      if (a == 0)
         return {enc(pair_z[0], pair_one[0], pair_zero[0]),
                 enc(pair_z[1], pair_one[1], pair_zero[1]),
                 ch, m_con, m_bias, m_dis};
      if (a == 1)
         return {(m_sv ? m_spd : 3'b000), m_ie, m_fault, 3'b000};
      return 8'h00;
   endfunction

   task automatic check(bit ok, string tag, int act, int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (!finished) begin
         bit eirq;
         eirq = m_ie && ((m_con != m_con_d) || (m_bias != m_bias_d) || (m_fault && !m_fault_d));
         check(reg_rdata == exp_read(reg_addr), "R1 R2 R3 R4 R5 R7 R8 R9 R10 R13 read-model",
               reg_rdata, exp_read(reg_addr));
         check(port_evt_irq == eirq, "R11 irq-model", port_evt_irq, eirq);
         check(child_vld == m_cv && spd_vld == m_sv, "R6 valid-model",
               {child_vld, spd_vld}, {m_cv, m_sv});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wr(bit [2:0] a, bit [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      step(1);
      reg_wr = 0;
   endtask

   task automatic rd(bit [2:0] a, bit [7:0] e, string tag);
      @(negedge clk); #1;
      reg_addr = a;
      #1;
      check(reg_rdata == e, tag, reg_rdata, e);
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         fails++; tests++;
         $display("FAIL R12 watchdog actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      step(3);
      hrst_n = 1;
      step(1);
      // R12 reset values
      rd(0, 8'h08, "R12 reset status byte");
      rd(1, 8'h00, "R12 reset peer byte");

      // R1 line encodings
      pair_z = 2'b01; pair_one = 2'b10;
      rd(0, 8'hD8, "R1 A=Z B=one");
      pair_z = 0; pair_one = 0; pair_zero = 2'b01;
      rd(0, 8'h88, "R1 A=zero B=invalid");
      pair_one = 2'b01; pair_zero = 2'b11;
      rd(0, 8'h28, "R1 A=conflict B=zero");
      pair_one = 0; pair_zero = 0;

      // R2 debounce with an interrupted run
      raw_conn = 1; step(CON - 1);
      raw_conn = 0; step(1);
      rd(0, 8'h08, "R2 short run gives no connection");
      raw_conn = 1; step(CON - 1);
      check(reg_rdata[2] == 0 || reg_addr != 0, "R2 not yet set", reg_rdata[2], 0);
      step(1);
      rd(0, 8'h0C, "R2 connection after full run");

      // R3 bias debounce
      raw_bias = 1; step(BIAS - 1);
      raw_bias = 0; step(1);
      raw_bias = 1; step(BIAS);
      rd(0, 8'h0E, "R3 bias after full run");

      // R4 parent result
      tree_child = 0; tree_done = 1; step(1); tree_done = 0;
      rd(0, 8'h06, "R4 parent reads child=0");
      check(child_vld == 1, "R4 child valid", child_vld, 1);

      // R5 forced child
      port_susp = 1;
      rd(0, 8'h0E, "R5 suspended reads child");
      port_susp = 0;
      wr(0, 8'hFF);
      rd(0, 8'h0F, "R5 R13 disabled reads child, read-only bits kept");

      // R8 disable survives bus reset, R6 invalidation
      peer_spd = 3'b010; selfid_done = 1; step(1); selfid_done = 0;
      rd(1, 8'h40, "R7 peer speed S400");
      bus_rst = 1; step(1); bus_rst = 0;
      rd(0, 8'h0F, "R8 R12 disable and status kept over bus reset");
      rd(1, 8'h00, "R6 speed reads 000 when invalid");
      check(child_vld == 0 && spd_vld == 0, "R6 valid flags cleared", {child_vld, spd_vld}, 0);
      wr(0, 8'h00);
      rd(0, 8'h0E, "R6 child reads 1 until tree id");
      bus_rst = 1; tree_done = 1; step(1); bus_rst = 0; tree_done = 0;
      check(child_vld == 0, "R6 bus reset wins over strobe", child_vld, 0);
      tree_done = 1; step(1); tree_done = 0;
      rd(0, 8'h06, "R4 parent again after tree id");

      // R9 enable, R10 faults, R11 interrupt
      wr(1, 8'h10);
      rd(1, 8'h10, "R9 enable set");
      rsm_chk = 1; step(1); rsm_chk = 0;
      rd(1, 8'h10, "R10 resume with bias gives no fault");
      sus_chk = 1; step(1); sus_chk = 0;
      check(port_evt_irq == 1, "R11 irq after fault", port_evt_irq, 1);
      step(1);
      check(port_evt_irq == 0, "R11 irq lasts one cycle", port_evt_irq, 0);
      rd(1, 8'h18, "R10 suspend fault latched");
      wr(1, 8'h18);
      rd(1, 8'h10, "R10 write one clears fault");
      reg_addr = 1; reg_wdata = 8'h18; reg_wr = 1; sus_chk = 1;
      step(1); reg_wr = 0; sus_chk = 0;
      rd(1, 8'h18, "R10 set wins over clear");
      wr(1, 8'h18);
      raw_bias = 0; step(1);
      check(port_evt_irq == 1, "R11 irq on bias drop", port_evt_irq, 1);
      rsm_chk = 1; step(1); rsm_chk = 0;
      rd(1, 8'h18, "R10 resume without bias faults");
      wr(1, 8'h08);
      raw_conn = 0; step(1);
      check(port_evt_irq == 0, "R11 no irq when disabled", port_evt_irq, 0);
      rd(1, 8'h00, "R9 R10 enable and fault cleared by write");

      // R13 reserved offsets
      wr(5, 8'hFF);
      rd(5, 8'h00, "R13 reserved reads zero");
      rd(1, 8'h00, "R13 reserved write ignored");

      // R12 hardware reset mid-run
      raw_conn = 1; raw_bias = 1; wr(0, 8'h01); wr(1, 8'h10);
      step(CON + 2);
      hrst_n = 0; step(2);
      rd(0, 8'h08, "R12 hardware reset clears status");
      rd(1, 8'h00, "R12 hardware reset clears controls");
      hrst_n = 1; raw_conn = 0; raw_bias = 0;
      step(3);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule